// File: doc/BRIEF.md
# Additive Scrambler with QPSK Symbol Mapper

The block makes a repeating pseudo random test bit stream, whitens it with an additive scrambler and groups the whitened bits into pairs. Each pair becomes one QPSK symbol, given as a pair of signed 2-bit values for the in-phase and quadrature rails. A second scrambler instance with the same seed runs on the scrambled stream as a loopback descrambler, so the original test bits can be recovered and compared on chip.

A strobe on `bit_vld_i` advances the whole chain by one bit. Without a strobe nothing moves. The test generator and the scrambler key generator both use the recurrence x^15 + x^14 + 1. Each is a 15-stage shift register: the new bit is the XOR of the two oldest stages, and it is shifted in at the bottom. The two generators start from different nonzero seeds. Because the descrambler starts from the scrambler seed at reset, the two stay aligned, and no frame or sync search is needed.

Top module: `scr_qpsk_top`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, every strobe output and every bit output is 0, and `i_o` and `q_o` are 2'b00.
- R2: The test generator has a 15-bit state s, with s[14] as the oldest stage and a seed of 15'h7FFF. On each strobe it forms f = s[14]^s[13], shifts in f (s becomes {s[13:0], f}) and emits f. In the cycle after the strobe, that bit appears on `prbs_bit_o` and `bit_vld_o` is 1.
- R3: The scrambler key register follows the same recurrence from seed 15'b100101010000000, with s[14] holding the leading 1. In the cycle after each strobe, `scr_bit_o` equals the key bit XOR the test bit for that strobe.
- R4: In the cycle after a cycle with no strobe, `bit_vld_o` is 0 and `prbs_bit_o` and `scr_bit_o` keep their previous values. Neither generator advances.
- R5: The first scrambled bit after reset opens a pair, and the bits after it alternate between closing and opening pairs. `sym_vld_o` is 1 exactly in the cycle after `bit_vld_o` has been 1 for a closing bit.
- R6: The opening bit of a pair sets `i_o` and the closing bit sets `q_o`. A 1 maps to +1 (2'b01) and a 0 maps to -1 (2'b11). So the pairs 00, 01, 10 and 11 give (-1,-1), (-1,+1), (+1,-1) and (+1,+1).
- R7: `i_o` and `q_o` keep their values in every cycle in which `sym_vld_o` is 0.
- R8: In the cycle after each `bit_vld_o`, `dsc_vld_o` is 1 and `dsc_bit_o` equals the `prbs_bit_o` value of the cycle before.
- R9: A reset in the middle of a stream restarts both generators from their seeds and restarts the pairing, so the next bit opens a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Advance the chain by one bit |
| bit_vld_o | output | 1 | New test and scrambled bits are present |
| prbs_bit_o | output | 1 | Test sequence bit |
| scr_bit_o | output | 1 | Scrambled bit |
| sym_vld_o | output | 1 | New symbol on i_o and q_o |
| i_o | output | 2 | In-phase value, signed, +1 or -1 |
| q_o | output | 2 | Quadrature value, signed, +1 or -1 |
| dsc_vld_o | output | 1 | Descrambled bit is present |
| dsc_bit_o | output | 1 | Descrambled bit |

## Verification
When a pair closes, one `bit_vld_o` pulse makes both the mapper emit a symbol and the descrambler emit a bit in the same cycle, while a new strobe may be moving the generators forward at the same edge. Runs of back-to-back strobes make all three coincide on every second cycle. Random gaps and a mid-stream reset shift the pairing phase against the strobe pattern. A bench model, written from the recurrences and the sign table alone, predicts the symbol, the descrambled bit and the next scrambled bit for every cycle.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;
  localparam int unsigned LFSR_W   = 15;
  localparam int unsigned TAP_HI   = 15;
  localparam int unsigned TAP_LO   = 14;
  localparam int unsigned IQ_W     = 2;
  localparam logic [LFSR_W-1:0] PRBS_SEED = 15'h7FFF;
  localparam logic [LFSR_W-1:0] SCR_SEED  = 15'b100101010000000;

  typedef logic signed [IQ_W-1:0] iq_t;
  localparam iq_t IQ_POS  = 2'sb01;
  localparam iq_t IQ_NEG  = 2'sb11;
  localparam iq_t IQ_ZERO = 2'sb00;

  function automatic iq_t sign_of(input logic b);
    return b ? IQ_POS : IQ_NEG;
  endfunction
endpackage

// File: rtl/lfsr_core.sv
module lfsr_core #(
  parameter int unsigned W      = 15,
  parameter int unsigned TAP_HI = 15,
  parameter int unsigned TAP_LO = 14,
  parameter logic [W-1:0] SEED  = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic key_o
);
  logic [W-1:0] state_q;

  assign key_o = state_q[TAP_HI-1] ^ state_q[TAP_LO-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= {state_q[W-2:0], key_o};
  end

  // R2 R3
  nonzero_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/add_scrambler.sv
module add_scrambler #(
  parameter int unsigned W      = 15,
  parameter int unsigned TAP_HI = 15,
  parameter int unsigned TAP_LO = 14,
  parameter logic [W-1:0] SEED  = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_vld_i,
  input  logic in_bit_i,
  output logic out_vld_o,
  output logic out_bit_o
);
  logic key;

  lfsr_core #(.W(W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED(SEED)) u_key (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (in_vld_i),
    .key_o (key)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o <= 1'b0;
      out_bit_o <= 1'b0;
    end else begin
      out_vld_o <= in_vld_i;
      if (in_vld_i) out_bit_o <= in_bit_i ^ key;
    end
  end

  // R4
  hold_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> $stable(out_bit_o));
endmodule

// File: rtl/pair_mapper.sv
module pair_mapper
  import qpsk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic sym_vld_o,
  output iq_t  i_o,
  output iq_t  q_o
);
  logic phase_q;
  logic first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= 1'b0;
      first_q   <= 1'b0;
      sym_vld_o <= 1'b0;
      i_o       <= IQ_ZERO;
      q_o       <= IQ_ZERO;
    end else begin
      sym_vld_o <= 1'b0;
      if (bit_vld_i) begin
        if (!phase_q) begin
          first_q <= bit_i;
          phase_q <= 1'b1;
        end else begin
          i_o       <= sign_of(first_q);
          q_o       <= sign_of(bit_i);
          sym_vld_o <= 1'b1;
          phase_q   <= 1'b0;
        end
      end
    end
  end

  // R5
  sym_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |=> !sym_vld_o);
  // R5
  sym_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |-> $past(bit_vld_i));
  // R6
  iq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |-> ((i_o == IQ_POS || i_o == IQ_NEG) && (q_o == IQ_POS || q_o == IQ_NEG)));
  // R7
  iq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_vld_o |-> ($stable(i_o) && $stable(q_o)));
endmodule

// File: rtl/scr_qpsk_top.sv
module scr_qpsk_top
  import qpsk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_vld_i,
  output logic       bit_vld_o,
  output logic       prbs_bit_o,
  output logic       scr_bit_o,
  output logic       sym_vld_o,
  output logic [1:0] i_o,
  output logic [1:0] q_o,
  output logic       dsc_vld_o,
  output logic       dsc_bit_o
);
  logic prbs_bit;
  logic scr_vld;
  iq_t  i_val, q_val;

  lfsr_core #(.W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED(PRBS_SEED)) u_prbs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (bit_vld_i),
    .key_o (prbs_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        prbs_bit_o <= 1'b0;
    else if (bit_vld_i) prbs_bit_o <= prbs_bit;
  end

  add_scrambler #(.W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED(SCR_SEED)) u_scr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_vld_i (bit_vld_i),
    .in_bit_i (prbs_bit),
    .out_vld_o(scr_vld),
    .out_bit_o(scr_bit_o)
  );

  assign bit_vld_o = scr_vld;

  add_scrambler #(.W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED(SCR_SEED)) u_dsc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_vld_i (scr_vld),
    .in_bit_i (scr_bit_o),
    .out_vld_o(dsc_vld_o),
    .out_bit_o(dsc_bit_o)
  );

  pair_mapper u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_vld_i(scr_vld),
    .bit_i    (scr_bit_o),
    .sym_vld_o(sym_vld_o),
    .i_o      (i_val),
    .q_o      (q_val)
  );

  assign i_o = i_val;
  assign q_o = q_val;

  // R8
  loopback_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_vld_o |-> (dsc_bit_o == $past(prbs_bit_o)));
  // R8
  dsc_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |=> dsc_vld_o);
endmodule

// File: tb/scr_qpsk_top_tb.sv
module scr_qpsk_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic bv_o, pb_o, sb_o, sv_o, dv_o, db_o;
  logic [1:0] i_o, q_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  scr_qpsk_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_vld_i(bit_vld),
    .bit_vld_o(bv_o), .prbs_bit_o(pb_o), .scr_bit_o(sb_o),
    .sym_vld_o(sv_o), .i_o(i_o), .q_o(q_o),
    .dsc_vld_o(dv_o), .dsc_bit_o(db_o)
  );

  // model state
  logic [14:0] ps, ks;
  logic e_bv, e_pb, e_sb, e_dv, e_db, e_sv, phase, first;
  logic [1:0] e_i, e_q;

  function automatic logic [1:0] sg(input logic b);
    return b ? 2'b01 : 2'b11;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    ps = 15'h7FFF; ks = 15'b100101010000000;
    e_bv = 0; e_pb = 0; e_sb = 0; e_dv = 0; e_db = 0; e_sv = 0;
    phase = 0; first = 0; e_i = 2'b00; e_q = 2'b00;
  endtask

  task automatic check_all();
    chk("R2 bit_vld", {3'b0, bv_o}, {3'b0, e_bv});
    chk("R2 prbs_bit", {3'b0, pb_o}, {3'b0, e_pb});
    chk("R3 scr_bit", {3'b0, sb_o}, {3'b0, e_sb});
    chk("R5 sym_vld", {3'b0, sv_o}, {3'b0, e_sv});
    chk("R6 R7 iq", {i_o, q_o}, {e_i, e_q});
    chk("R8 dsc_vld", {3'b0, dv_o}, {3'b0, e_dv});
    if (e_dv) chk("R8 dsc_bit", {3'b0, db_o}, {3'b0, e_db});
    if (!e_bv) chk("R4 hold", {2'b0, pb_o, sb_o}, {2'b0, e_pb, e_sb});
  endtask

  task automatic cycle(input logic v);
    logic f, k;
    bit_vld = v;
    e_dv = e_bv;
    if (e_bv) e_db = e_pb;
    e_sv = 0;
    if (e_bv) begin
      if (!phase) begin first = e_sb; phase = 1; end
      else begin e_sv = 1; e_i = sg(first); e_q = sg(e_sb); phase = 0; end
    end
    e_bv = v;
    if (v) begin
      f = ps[14] ^ ps[13]; ps = {ps[13:0], f};
      k = ks[14] ^ ks[13]; ks = {ks[13:0], k};
      e_pb = f; e_sb = f ^ k;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst_n = 0; bit_vld = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk({tag, " R1 outs"}, {bv_o, pb_o, sb_o, sv_o}, 4'b0);
    chk({tag, " R1 iq"}, {i_o, q_o}, 4'b0);
    chk({tag, " R1 dsc"}, {2'b0, dv_o, db_o}, 4'b0);
    rst_n = 1;
  endtask

  initial begin
    #(5ns * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    do_reset("init");
    cycle(1'b0);                     // R1 first cycle after release
    repeat (300) cycle(1'b1);        // back-to-back: symbol + dsc + strobe coincide
    repeat (20) cycle(1'b0);         // R4 stall
    cycle(1'b1); cycle(1'b0); cycle(1'b0); cycle(1'b1); // split pair, R5
    for (int n = 0; n < 3000; n++) cycle(($urandom % 100) < 60);
    repeat (5) cycle(1'b1);
    do_reset("R9 mid");              // R9 restart of generators and pairing
    for (int n = 0; n < 400; n++) cycle(1'b1);
    for (int n = 0; n < 2000; n++) cycle(($urandom % 100) < 30);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule